// File: doc/BRIEF.md
# NMI pin qualifier with stop-mode interlock

This block sits between the non-maskable interrupt pin and a small CPU core. The pin passes through a synchronizer. A falling edge of the synchronized level becomes a single-cycle interrupt request, but only after software has switched the function on. The switch is a set-only bit: once software writes it to 1, no write can turn it off, and only reset clears it.

The block also guards the stop-mode control bit. While the function is on and the pin reads low, that bit is forced to 0 and software cannot set it, so the clock cannot be stopped with an NMI already pending. The block watches the length of every low and high phase of the synchronized pin. It reports a phase shorter than the minimum width with a one-cycle flag, and it does not hold back the request that phase produces.

The synchronized pin level is available as a status bit. Requests depend only on the pin and the enable bit, with no reference to any CPU sleep state, so a falling pin also wakes a core that is waiting.

Top module: `nmi_guard`

## Requirements
- R1: After reset release with the pin held high, `nmi_req`, `stop_ctl` and `width_err` are 0 and `pin_status` is 1.
- R2: While the enable bit is 0, no falling pin edge produces `nmi_req`.
- R3: A cycle with `cfg_we`=1 and `cfg_wdata`=1 sets the enable bit from the next clock edge. A later write with `cfg_wdata`=0 leaves it set, and only reset clears it.
- R4: With the enable bit set, a pin driven low just after clock edge n makes `nmi_req` high for exactly the cycle after edge n+2. A rising pin produces no request.
- R5: `pin_status` takes a pin change made just after edge n at edge n+2.
- R6: While the enable bit is set and `pin_status` is 0, `stop_ctl` reads 0 and a stop write of 1 has no effect.
- R7: While the enable bit is clear or `pin_status` is 1, a stop write (`stop_we`=1) loads `stop_wdata` into `stop_ctl` at the next edge. A bit cleared by the hold stays 0 after the pin returns high, until software writes it again.
- R8: A synchronized phase that lies between two transitions and lasts fewer than MIN_PHASE (default 2) cycles raises `width_err` for one cycle. The flag rises on the edge after the `pin_status` change that ends the phase. Phases of MIN_PHASE cycles or longer raise no flag, and the phase that runs from reset to the first transition is not checked.
- R9: A low phase that is too short still produces its request when enabled.
- R10: The width check runs whether or not the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | asynchronous active-low reset |
| nmi_pin | input | 1 | asynchronous NMI pin level |
| cfg_we | input | 1 | enable-register write strobe |
| cfg_wdata | input | 1 | enable-register write data (1 sets) |
| stop_we | input | 1 | stop-control write strobe |
| stop_wdata | input | 1 | stop-control write data |
| nmi_req | output | 1 | one-cycle NMI request |
| pin_status | output | 1 | synchronized pin level |
| stop_ctl | output | 1 | stop-mode control bit after interlock |
| width_err | output | 1 | one-cycle phase-width violation flag |

## Verification
The pin is driven with long low and high phases, with one-cycle low and high glitches, and with phases of exactly the minimum width. Each pattern is run both before and after the enable bit is set. The long phases separate correct request timing from missing requests or extra requests on rising edges. The one-cycle phases and the exact-minimum phases find an off-by-one in the width comparison. Running before and after enabling shows that the requests are gated by the enable bit while the width check is not. Stop writes are issued with the pin low, after the pin returns high, and with the function still disabled. These writes separate the forced hold from a plain write path, and they show whether the bit recovers on its own when the pin goes high.

// File: rtl/nmi_guard_pkg.sv
package nmi_guard_pkg;

  // next value of a run-length counter that stops at lim
  function automatic int unsigned run_next(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // a finished phase of len cycles breaks the width rule
  function automatic logic phase_too_short(input int unsigned len, input int unsigned min_len);
    return len < min_len;
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= pin_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b1;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = prev_q;

  initial begin
    AST_MIN_STAGES: assert (STAGES >= 2); // R5
  end
endmodule

// File: rtl/nmi_width_mon.sv
module nmi_width_mon
  import nmi_guard_pkg::*;
#(
  parameter int MIN_PHASE = 2,
  localparam int CNT_W = $clog2(MIN_PHASE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic prev_i,
  output logic err_o
);
  logic [CNT_W-1:0] run_q;
  logic             seen_q;
  logic             err_q;
  logic             change;
  logic             short_end;

  assign change    = level_i ^ prev_i;
  assign short_end = change && seen_q &&
                     phase_too_short(int'(run_q), MIN_PHASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= short_end;
      if (change) begin
        run_q  <= CNT_W'(1);
        seen_q <= 1'b1;
      end else begin
        run_q <= CNT_W'(run_next(int'(run_q), MIN_PHASE));
      end
    end
  end

  assign err_o = err_q;

  AST_ERR_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(level_i != prev_i)); // R8
endmodule

// File: rtl/nmi_ctrl.sv
module nmi_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_wdata,
  input  logic stop_we,
  input  logic stop_wdata,
  input  logic level_i,
  output logic en_o,
  output logic stop_o
);
  logic en_q;
  logic stop_q;
  logic hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   en_q <= 1'b0;
    else if (cfg_we && cfg_wdata) en_q <= 1'b1;
  end

  assign hold = en_q && !level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stop_q <= 1'b0;
    else if (hold)    stop_q <= 1'b0;
    else if (stop_we) stop_q <= stop_wdata;
  end

  assign en_o   = en_q;
  assign stop_o = stop_q && !hold;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R3
  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !stop_q); // R6
endmodule

// File: rtl/nmi_guard.sv
module nmi_guard #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PHASE   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pin,
  input  logic cfg_we,
  input  logic cfg_wdata,
  input  logic stop_we,
  input  logic stop_wdata,
  output logic nmi_req,
  output logic pin_status,
  output logic stop_ctl,
  output logic width_err
);
  logic lvl;
  logic prv;
  logic en;
  logic fall_seen;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(nmi_pin), .level_o(lvl), .prev_o(prv)
  );

  nmi_width_mon #(.MIN_PHASE(MIN_PHASE)) u_width (
    .clk(clk), .rst_n(rst_n), .level_i(lvl), .prev_i(prv), .err_o(width_err)
  );

  nmi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .stop_we(stop_we), .stop_wdata(stop_wdata), .level_i(lvl),
    .en_o(en), .stop_o(stop_ctl)
  );

  assign fall_seen  = prv && !lvl;
  assign nmi_req    = en && fall_seen;
  assign pin_status = lvl;

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> en); // R2
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req); // R4
  AST_STOP_LOW_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pin_status) |-> !stop_ctl); // R6
endmodule

// File: tb/nmi_guard_tb.sv
module nmi_guard_tb;
  localparam int MINP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 1'b1;
  logic cfg_we = 1'b0, cfg_wdata = 1'b0, stop_we = 1'b0, stop_wdata = 1'b0;
  logic nmi_req, pin_status, stop_ctl, width_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit en_exp = 1'b0;
  bit have_edge = 1'b0;
  int last_edge = 0;
  int req_q[$];
  int err_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nmi_guard #(.SYNC_STAGES(2), .MIN_PHASE(MINP)) u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .stop_we(stop_we), .stop_wdata(stop_wdata),
    .nmi_req(nmi_req), .pin_status(pin_status), .stop_ctl(stop_ctl),
    .width_err(width_err)
  );

  task automatic check(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, got, exp);
    end
  endtask

  // driver: sets the pin and predicts requests (R2 R4 R9) and width flags (R8 R10)
  task automatic drive_pin(input logic v, input int hold);
    @(negedge clk);
    if (v != nmi_pin) begin
      if (!v && en_exp) req_q.push_back(cyc + 2);
      if (have_edge && (cyc - last_edge) < MINP) err_q.push_back(cyc + 3);
      have_edge = 1'b1;
      last_edge = cyc;
    end
    nmi_pin = v;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    if (v) en_exp = 1'b1;
  endtask

  task automatic wr_stop(input logic v);
    @(negedge clk); stop_we = 1'b1; stop_wdata = v;
    @(negedge clk); stop_we = 1'b0;
  endtask

  // monitor: pops predicted events as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (nmi_req) begin
        total++;
        if (req_q.size() == 0 || req_q[0] != cyc) begin
          bad++;
          $display("FAIL R4 request cyc=%0d actual=1 expected=%0d",
                   cyc, (req_q.size() != 0) ? req_q[0] : -1);
        end
        if (req_q.size() != 0 && req_q[0] <= cyc) void'(req_q.pop_front());
      end else if (req_q.size() != 0 && req_q[0] <= cyc) begin
        total++; bad++;
        $display("FAIL R4 missing request cyc=%0d actual=0 expected=1", cyc);
        void'(req_q.pop_front());
      end
      if (width_err) begin
        total++;
        if (err_q.size() == 0 || err_q[0] != cyc) begin
          bad++;
          $display("FAIL R8 width flag cyc=%0d actual=1 expected=%0d",
                   cyc, (err_q.size() != 0) ? err_q[0] : -1);
        end
        if (err_q.size() != 0 && err_q[0] <= cyc) void'(err_q.pop_front());
      end else if (err_q.size() != 0 && err_q[0] <= cyc) begin
        total++; bad++;
        $display("FAIL R8 missing width flag cyc=%0d actual=0 expected=1", cyc);
        void'(err_q.pop_front());
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 nmi_req", nmi_req, 1'b0);
    check("R1 stop_ctl", stop_ctl, 1'b0);
    check("R1 width_err", width_err, 1'b0);
    check("R1 pin_status", pin_status, 1'b1);

    // R5 status latency, R2 no request while disabled
    drive_pin(1'b0, 1);
    @(negedge clk); check("R5 status before edge n+2", pin_status, 1'b1);
    @(negedge clk); check("R5 status at edge n+2", pin_status, 1'b0);
    repeat (3) @(negedge clk);

    // R7 stop writes work while disabled even with the pin low
    wr_stop(1'b1); check("R7 stop set while disabled", stop_ctl, 1'b1);
    wr_stop(1'b0); check("R7 stop clear", stop_ctl, 1'b0);
    drive_pin(1'b1, 6);

    // R10 width check without enable: one-cycle low glitch
    drive_pin(1'b0, 1);
    drive_pin(1'b1, 6);

    // R3 enable
    wr_cfg(1'b1);
    drive_pin(1'b0, 5);          // R4 long low
    drive_pin(1'b1, 5);          // R4 no request on rise
    wr_cfg(1'b0);                // R3 write of 0 keeps enable
    drive_pin(1'b0, 4);
    drive_pin(1'b1, 4);

    // R9 R8 short phases and exact minimum
    drive_pin(1'b0, 1);
    drive_pin(1'b1, 1);
    drive_pin(1'b0, MINP);
    drive_pin(1'b1, MINP);
    drive_pin(1'b0, 6);
    drive_pin(1'b1, 6);

    // R6 interlock while low
    drive_pin(1'b0, 4);
    check("R6 status low", pin_status, 1'b0);
    wr_stop(1'b1); check("R6 stop write ignored", stop_ctl, 1'b0);
    drive_pin(1'b1, 4);
    check("R7 stays 0 after release", stop_ctl, 1'b0);
    wr_stop(1'b1); check("R7 stop set after release", stop_ctl, 1'b1);
    drive_pin(1'b0, 3);
    check("R6 low pin forces stop to 0", stop_ctl, 1'b0);
    drive_pin(1'b1, 4);
    check("R7 stop not restored", stop_ctl, 1'b0);
    wr_stop(1'b0); check("R7 stop clear when high", stop_ctl, 1'b0);

    repeat (8) @(negedge clk);
    check("R4 all requests seen", logic'(req_q.size() == 0), 1'b1);
    check("R8 all width flags seen", logic'(err_q.size() == 0), 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule